// File: doc/BRIEF.md
# PLL Synthesizer Configuration Register with Parallel and Serial Load

This block holds the configuration word for a PLL clock synthesizer. The word has three fields: a 9-bit feedback divider value, a 2-bit post-divider select and a 3-bit test-observation select. The PLL, oscillator and output drivers are outside the block. The block only keeps the word and presents it to them. It also decodes the post-divider select into a one-hot ratio, and it raises a one-cycle pulse whenever the held word changes.

The word can be written through two paths, and both write the same latches.

- **Parallel path.** It takes the divider value and the post-divider select from level pins when its strobe rises. It always clears the test select.
- **Serial path.** It clocks a 14-bit frame into a shift register, most significant bit first. A separate load strobe then moves the whole frame into the latches on that strobe's falling edge. This path acts only while the parallel strobe is high.

When both paths fire together, the parallel path wins. Every pin is asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and each strobe is turned into a single-cycle event by an edge detector.

Top module: `synth_cfg_reg`

## Requirements
- R1: After reset, the divider value is 0, the post-divider select is 0, the test select is 0, the decoded ratio is 4'b0001 and the update pulse is low.
- R2: Each rising edge of the serial clock pin shifts the serial data pin into the bottom of a 14-bit shift register. Only the last 14 bits shifted are kept. Frame bits [13:11] are the test select, bits [10:9] are the post-divider select and bits [8:0] are the divider value, so the divider's bit 0 is shifted last.
- R3: A falling edge of the serial load pin, while the parallel strobe is high, copies the whole shift register into the divider, post-divider and test-select outputs.
- R4: A falling edge of the serial load pin while the parallel strobe is low leaves all outputs unchanged and raises no update pulse. The shift register keeps its contents.
- R5: A rising edge of the parallel strobe loads the divider and post-divider outputs from their pins and sets the test select to 000. A falling edge of the parallel strobe changes nothing.
- R6: When a parallel rising edge and a serial falling edge are detected in the same cycle, the parallel values are loaded.
- R7: The decoded ratio output is one-hot: select 0, 1, 2 and 3 give 4'b0001, 4'b0010, 4'b0100 and 4'b1000 (divide by 1, 2, 4 and 8).
- R8: The update output is high for exactly one cycle, in the same cycle the held word takes a new value. A load that writes the value already held raises no pulse.
- R9: Serial clock edges and shifting alone never change the held outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClkPin | input | 1 | Serial shift clock pin (asynchronous) |
| serDataPin | input | 1 | Serial data pin, sampled on serial clock rise |
| serLoadPin | input | 1 | Serial transfer strobe, acts on its falling edge |
| parLoadPin | input | 1 | Parallel strobe, captures on its rising edge |
| parMPin | input | 9 | Parallel divider value pins |
| parNPin | input | 2 | Parallel post-divider select pins |
| cfgM | output | 9 | Held feedback divider value |
| cfgN | output | 2 | Held post-divider select |
| cfgT | output | 3 | Held test-observation select |
| postDiv | output | 4 | One-hot decoded post-divide ratio |
| cfgUpdate | output | 1 | One-cycle pulse when the held word changes |

## Verification
The hardest case to reach is a parallel rising edge and a serial falling edge that land in the same system clock cycle after synchronization. The bench gets there by holding the serial load pin high with the parallel strobe low. It then flips both pins at the same clock edge, so that both pass through identical synchronizer depth. A second hard case is a serial load that is blocked while the parallel strobe is low. The bench shows that the shift register survives the blocked load by issuing a later serial load with no new shifting, which must deliver the frame that was shifted before.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W = 9;
  localparam int N_W = 2;
  localparam int T_W = 3;
  localparam int FRAME_W = T_W + N_W + M_W;
  localparam int RATIO_W = 1 << N_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfgWord_t;

  typedef struct packed {
    logic shiftBit;
    logic takeSerial;
    logic takeParallel;
  } cfgStrobe_t;

  function automatic logic [RATIO_W-1:0] decodeRatio(input logic [N_W-1:0] sel);
    logic [RATIO_W-1:0] r;
    r = '0;
    for (int i = 0; i < RATIO_W; i++) begin
      if (sel == N_W'(i)) r[i] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           serClkPin,
  input  logic           serDataPin,
  input  logic           serLoadPin,
  input  logic           parLoadPin,
  input  logic [M_W-1:0] parMPin,
  input  logic [N_W-1:0] parNPin,
  output cfgStrobe_t     strobe,
  output logic           serBit,
  output logic [M_W-1:0] parM,
  output logic [N_W-1:0] parN
);
  localparam int SW = 4 + M_W + N_W;

  logic [SW-1:0] syncIn;
  logic [SW-1:0] syncOut;
  logic sClk, sLoad, pLoad;
  logic prevClk, prevLoad, prevPar;
  logic parRise, serFall;

  assign syncIn = {serClkPin, serDataPin, serLoadPin, parLoadPin, parMPin, parNPin};

  synth_cfg_sync #(.WIDTH(SW), .STAGES(STAGES)) uSync (
    .clk(clk), .rstN(rstN), .din(syncIn), .dout(syncOut)
  );

  assign {sClk, serBit, sLoad, pLoad, parM, parN} = syncOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk  <= 1'b0;
      prevLoad <= 1'b0;
      prevPar  <= 1'b0;
    end else begin
      prevClk  <= sClk;
      prevLoad <= sLoad;
      prevPar  <= pLoad;
    end
  end

  assign parRise = pLoad & ~prevPar;
  assign serFall = ~sLoad & prevLoad;

  always_comb begin
    strobe.shiftBit     = sClk & ~prevClk;
    strobe.takeParallel = parRise;
    strobe.takeSerial   = serFall & pLoad & ~parRise;
  end
endmodule

// File: rtl/synth_cfg_datapath.sv
module synth_cfg_datapath
  import synth_cfg_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  cfgStrobe_t     strobe,
  input  logic           serBit,
  input  logic [M_W-1:0] parM,
  input  logic [N_W-1:0] parN,
  output cfgWord_t       word,
  output logic           updatePulse
);
  logic [FRAME_W-1:0] shiftReg;
  cfgWord_t parWord;
  cfgWord_t nextWord;
  logic     loadAny;

  assign parWord = '{t: '0, n: parN, m: parM};

  always_comb begin
    nextWord = word;
    loadAny  = 1'b0;
    if (strobe.takeParallel) begin
      nextWord = parWord;
      loadAny  = 1'b1;
    end else if (strobe.takeSerial) begin
      nextWord = cfgWord_t'(shiftReg);
      loadAny  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      word        <= '0;
      updatePulse <= 1'b0;
    end else begin
      if (strobe.shiftBit) shiftReg <= {shiftReg[FRAME_W-2:0], serBit};
      word        <= nextWord;
      updatePulse <= loadAny && (nextWord != word);
    end
  end
endmodule

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClkPin,
  input  logic               serDataPin,
  input  logic               serLoadPin,
  input  logic               parLoadPin,
  input  logic [M_W-1:0]     parMPin,
  input  logic [N_W-1:0]     parNPin,
  output logic [M_W-1:0]     cfgM,
  output logic [N_W-1:0]     cfgN,
  output logic [T_W-1:0]     cfgT,
  output logic [RATIO_W-1:0] postDiv,
  output logic               cfgUpdate
);
  cfgStrobe_t     strobe;
  logic           serBit;
  logic [M_W-1:0] parM;
  logic [N_W-1:0] parN;
  cfgWord_t       word;

  synth_cfg_ctrl #(.STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .serClkPin(serClkPin), .serDataPin(serDataPin),
    .serLoadPin(serLoadPin), .parLoadPin(parLoadPin),
    .parMPin(parMPin), .parNPin(parNPin),
    .strobe(strobe), .serBit(serBit), .parM(parM), .parN(parN)
  );

  synth_cfg_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .serBit(serBit),
    .parM(parM), .parN(parN), .word(word), .updatePulse(cfgUpdate)
  );

  assign cfgM    = word.m;
  assign cfgN    = word.n;
  assign cfgT    = word.t;
  assign postDiv = decodeRatio(word.n);
endmodule

// File: rtl/synth_cfg_reg_chk.sv
module synth_cfg_reg_chk
  import synth_cfg_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               parLoadPin,
  input logic [M_W-1:0]     cfgM,
  input logic [N_W-1:0]     cfgN,
  input logic [T_W-1:0]     cfgT,
  input logic [RATIO_W-1:0] postDiv,
  input logic               cfgUpdate
);
  logic [FRAME_W-1:0] held;
  assign held = {cfgT, cfgN, cfgM};

  AST_RATIO_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(postDiv) == 1) else $error("ratio not one-hot"); // R7

  AST_RATIO_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgN == 2'd3) |-> postDiv[3]) else $error("ratio for select 3"); // R7

  AST_UPDATE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cfgUpdate |=> !cfgUpdate) else $error("update longer than one cycle"); // R8

  AST_UPDATE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(held) |-> cfgUpdate) else $error("change without update"); // R8

  AST_UPDATE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    cfgUpdate |-> !$stable(held)) else $error("update without change"); // R8

  AST_PAR_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(parLoadPin, 2) |-> $stable(held)) else $error("change while strobe low"); // R4
endmodule

bind synth_cfg_reg synth_cfg_reg_chk uChk (
  .clk(clk), .rstN(rstN), .parLoadPin(parLoadPin),
  .cfgM(cfgM), .cfgN(cfgN), .cfgT(cfgT), .postDiv(postDiv), .cfgUpdate(cfgUpdate)
);

// File: tb/synth_cfg_reg_test.sv
module synth_cfg_reg_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClkPin = 1'b0, serDataPin = 1'b0, serLoadPin = 1'b0, parLoadPin = 1'b0;
  logic [8:0] parMPin = '0;
  logic [1:0] parNPin = '0;
  logic [8:0] cfgM;
  logic [1:0] cfgN;
  logic [2:0] cfgT;
  logic [3:0] postDiv;
  logic cfgUpdate;

  int checks = 0, fails = 0, updCount = 0;
  logic [13:0] expWord = '0;
  int expUpd = 0;
  bit done = 0;

  always #5 clk = ~clk;

  synth_cfg_reg uut (
    .clk(clk), .rstN(rstN), .serClkPin(serClkPin), .serDataPin(serDataPin),
    .serLoadPin(serLoadPin), .parLoadPin(parLoadPin), .parMPin(parMPin), .parNPin(parNPin),
    .cfgM(cfgM), .cfgN(cfgN), .cfgT(cfgT), .postDiv(postDiv), .cfgUpdate(cfgUpdate)
  );

  always @(negedge clk) if (rstN && cfgUpdate) updCount++;

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk(req, {cfgT, cfgN, cfgM}, expWord);
    chk({req, " ratio R7"}, postDiv, 4'b0001 << expWord[10:9]);
    chk({req, " update R8"}, updCount, expUpd);
  endtask

  task automatic note(input logic [13:0] w);
    if (w != expWord) expUpd++;
    expWord = w;
  endtask

  task automatic shiftBits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serDataPin = bits[i];
      serClkPin = 1'b0; waitC(4);
      serClkPin = 1'b1; waitC(4);
    end
    serClkPin = 1'b0; waitC(4);
  endtask

  task automatic serLoad();
    serLoadPin = 1'b1; waitC(5);
    serLoadPin = 1'b0; waitC(6);
  endtask

  task automatic parLoad(input logic [8:0] m, input logic [1:0] n);
    parLoadPin = 1'b0; waitC(5);
    parMPin = m; parNPin = n; waitC(4);
    parLoadPin = 1'b1; waitC(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    waitC(3);
    rstN = 1'b1;
    waitC(3);
    // R1 reset state
    chk("R1 word", {cfgT, cfgN, cfgM}, 14'd0);
    chk("R1 ratio", postDiv, 4'b0001);
    chk("R1 update", cfgUpdate, 1'b0);

    // R5 R7 parallel sweep over every post-divider select
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < 3; k++) begin
        logic [8:0] m;
        m = 9'((n * 97 + k * 131 + 5) % 512);
        parLoad(m, 2'(n));
        note({3'b000, 2'(n), m});
        checkAll("R5 parallel");
      end
    end
    // R8 identical reload gives no pulse
    parLoad(expWord[8:0], expWord[10:9]);
    checkAll("R8 same value");
    // R5 falling parallel strobe changes nothing
    parLoadPin = 1'b0; waitC(8);
    checkAll("R5 falling strobe");
    parLoadPin = 1'b1; parMPin = 9'h1F0; parNPin = 2'd2; waitC(8);
    note({3'b000, 2'd2, 9'h1F0});
    checkAll("R5 reload");

    // R2 R3 serial sweep over all test-select codes
    for (int t = 0; t < 8; t++) begin
      logic [13:0] f;
      f = {3'(t), 2'(t % 4), 9'((t * 61 + 17) % 512)};
      shiftBits({18'd0, f}, 14);
      chk("R9 shift only", {cfgT, cfgN, cfgM}, expWord);
      serLoad();
      note(f);
      checkAll("R3 serial");
    end

    // R2 over-long shift keeps last 14 bits
    shiftBits(32'h0005_2E71, 20);
    serLoad();
    note(14'h2E71);
    checkAll("R2 last 14 bits");

    // R4 serial load with parallel strobe low is ignored
    parMPin = 9'h033; parNPin = 2'd1;
    parLoadPin = 1'b0; waitC(6);
    shiftBits({18'd0, 14'h1A5C}, 14);
    serLoad();
    checkAll("R4 ignored");
    parLoadPin = 1'b1; waitC(8);
    note({3'b000, 2'd1, 9'h033});
    checkAll("R5 after block");
    serLoad();
    note(14'h1A5C);
    checkAll("R4 shift kept");

    // R6 simultaneous edges: parallel wins
    parLoadPin = 1'b0; serLoadPin = 1'b1;
    parMPin = 9'h0C3; parNPin = 2'd3; waitC(6);
    parLoadPin = 1'b1; serLoadPin = 1'b0; waitC(8);
    note({3'b000, 2'd3, 9'h0C3});
    checkAll("R6 priority");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule